// File: doc/BRIEF.md
# Single-Level Return Address Register

This block keeps the program counter of a small 8-bit core with 14-bit addressing, together with a one-deep shadow register that stores a return address. A subroutine call loads the program counter with the call target and places the return address, which the caller supplies, in the shadow register. No memory is written. A return loads the program counter from the shadow register. Because only one return address is held, a second call overwrites the first one.

For nested calls, firmware moves the saved address through the accumulator one byte at a time. Two exchange strobes swap the accumulator with the upper or the lower byte of the shadow register. The old byte comes back on a registered output, marked valid for one cycle, and the accumulator value goes into the shadow register. The upper byte has only six significant bits. It is returned zero-extended, and only the six low accumulator bits are stored.

The work is split into three parts. An operation selector resolves the strobes into one program-counter operation (hold, step, jump, return) and one shadow operation (hold, save, exchange-high, exchange-low). These operations act as the per-cycle states. A program-counter register and a shadow register carry out the selected operation. The selector applies this order: call before return, return before step, and for the shadow register, save before exchange-high before exchange-low.

Top module: `rtsave_unit`

## Requirements
- R1: After reset, pc and spc are 0 and acc_vld is 0.
- R2: With step_en high and neither call_en nor ret_en high, pc becomes (pc + step_inc) mod 16384 on the next edge, for step_inc from 0 to 3.
- R3: With call_en high, pc becomes call_target and spc becomes ret_addr on the next edge.
- R4: With ret_en high and call_en low, pc becomes the spc value held before that edge.
- R5: When call_en is high, ret_en and step_en have no effect on pc and spc.
- R6: When ret_en is high and call_en is low, step_en has no effect on pc.
- R7: A second call with no exchange in between replaces the first saved return address, so a later return goes to the second one.
- R8: With xchg_hi high and call_en low, on the next edge acc_vld is 1, acc_out equals {2'b00, old spc[13:8]}, spc[13:8] takes acc_in[5:0], and spc[7:0] does not change.
- R9: With xchg_lo high and xchg_hi and call_en low, on the next edge acc_vld is 1, acc_out equals the old spc[7:0], spc[7:0] takes acc_in, and spc[13:8] does not change.
- R10: When xchg_hi and xchg_lo are high together without call_en, only the high exchange takes place.
- R11: When call_en is high, both exchange strobes are ignored: acc_vld is 0 on the next edge and spc holds ret_addr.
- R12: With no strobe high, pc and spc keep their values and acc_vld is 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Advance pc by step_inc |
| step_inc | input | 2 | Byte count to add to pc |
| call_en | input | 1 | Call strobe |
| ret_en | input | 1 | Return strobe |
| call_target | input | 14 | Address to jump to on a call |
| ret_addr | input | 14 | Return address to save on a call |
| xchg_hi | input | 1 | Swap the accumulator with spc high byte |
| xchg_lo | input | 1 | Swap the accumulator with spc low byte |
| acc_in | input | 8 | Accumulator value |
| pc | output | 14 | Program counter |
| spc | output | 14 | Shadow (return address) register |
| acc_out | output | 8 | Byte returned by an exchange |
| acc_vld | output | 1 | acc_out holds a new exchange result |

## Verification
The hardest cases to reach are those where several strobes are high in the same cycle. Examples are a return together with an exchange, where pc has to take the shadow value from before the exchange, and a call that overrides both exchanges. The bench covers these by driving all 32 combinations of the five strobes from many different register contents. It also sweeps every accumulator value through both exchanges, so that the masking of the high byte to six bits shows up at the output.

// File: rtl/rtsave_pkg.sv
package rtsave_pkg;
    typedef enum logic [1:0] {
        PC_HOLD   = 2'd0,
        PC_STEP   = 2'd1,
        PC_JUMP   = 2'd2,
        PC_RETURN = 2'd3
    } pc_op_e;

    typedef enum logic [1:0] {
        SH_HOLD = 2'd0,
        SH_SAVE = 2'd1,
        SH_XHI  = 2'd2,
        SH_XLO  = 2'd3
    } sh_op_e;
endpackage

// File: rtl/rtsave_opsel.sv
module rtsave_opsel
    import rtsave_pkg::*;
(
    input  logic   step_en,
    input  logic   call_en,
    input  logic   ret_en,
    input  logic   xchg_hi,
    input  logic   xchg_lo,
    output pc_op_e pc_op,
    output sh_op_e sh_op
);
    // Program counter: call, then return, then step.
    always_comb begin
        if (call_en)      pc_op = PC_JUMP;
        else if (ret_en)  pc_op = PC_RETURN;
        else if (step_en) pc_op = PC_STEP;
        else              pc_op = PC_HOLD;
    end

    // Shadow register: save on call, then high exchange, then low exchange.
    always_comb begin
        if (call_en)      sh_op = SH_SAVE;
        else if (xchg_hi) sh_op = SH_XHI;
        else if (xchg_lo) sh_op = SH_XLO;
        else              sh_op = SH_HOLD;
    end
endmodule

// File: rtl/rtsave_pc.sv
module rtsave_pc
    import rtsave_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int INC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pc_op_e            pc_op,
    input  logic [INC_W-1:0]  step_inc,
    input  logic [ADDR_W-1:0] call_target,
    input  logic [ADDR_W-1:0] spc_cur,
    output logic [ADDR_W-1:0] pc
);
    logic [ADDR_W-1:0] pc_q, pc_n;

    always_comb begin
        unique case (pc_op)
            PC_HOLD:   pc_n = pc_q;
            PC_STEP:   pc_n = pc_q + ADDR_W'(step_inc);
            PC_JUMP:   pc_n = call_target;
            PC_RETURN: pc_n = spc_cur;
            default:   pc_n = pc_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_n;
    end

    assign pc = pc_q;
endmodule

// File: rtl/rtsave_shadow.sv
module rtsave_shadow
    import rtsave_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sh_op_e            sh_op,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [DATA_W-1:0] acc_in,
    output logic [ADDR_W-1:0] spc,
    output logic [DATA_W-1:0] acc_out,
    output logic              acc_vld
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] spc_q, spc_n;
    logic [DATA_W-1:0] acc_q, acc_n;
    logic              vld_q, vld_n;

    always_comb begin
        spc_n = spc_q;
        acc_n = acc_q;
        vld_n = 1'b0;
        unique case (sh_op)
            SH_HOLD: ;
            SH_SAVE: spc_n = ret_addr;
            SH_XHI: begin
                spc_n = {acc_in[HI_W-1:0], spc_q[DATA_W-1:0]};
                acc_n = DATA_W'(spc_q[ADDR_W-1:DATA_W]);
                vld_n = 1'b1;
            end
            SH_XLO: begin
                spc_n = {spc_q[ADDR_W-1:DATA_W], acc_in};
                acc_n = spc_q[DATA_W-1:0];
                vld_n = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spc_q <= '0;
            acc_q <= '0;
            vld_q <= 1'b0;
        end else begin
            spc_q <= spc_n;
            acc_q <= acc_n;
            vld_q <= vld_n;
        end
    end

    assign spc     = spc_q;
    assign acc_out = acc_q;
    assign acc_vld = vld_q;
endmodule

// File: rtl/rtsave_unit.sv
module rtsave_unit
    import rtsave_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8,
    parameter int INC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [INC_W-1:0]  step_inc,
    input  logic              call_en,
    input  logic              ret_en,
    input  logic [ADDR_W-1:0] call_target,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic              xchg_hi,
    input  logic              xchg_lo,
    input  logic [DATA_W-1:0] acc_in,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] spc,
    output logic [DATA_W-1:0] acc_out,
    output logic              acc_vld
);
    pc_op_e pc_op;
    sh_op_e sh_op;

    rtsave_opsel u_opsel (
        .step_en (step_en),
        .call_en (call_en),
        .ret_en  (ret_en),
        .xchg_hi (xchg_hi),
        .xchg_lo (xchg_lo),
        .pc_op   (pc_op),
        .sh_op   (sh_op)
    );

    rtsave_pc #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .pc_op       (pc_op),
        .step_inc    (step_inc),
        .call_target (call_target),
        .spc_cur     (spc),
        .pc          (pc)
    );

    rtsave_shadow #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .sh_op    (sh_op),
        .ret_addr (ret_addr),
        .acc_in   (acc_in),
        .spc      (spc),
        .acc_out  (acc_out),
        .acc_vld  (acc_vld)
    );
endmodule

// File: rtl/rtsave_checker.sv
module rtsave_checker #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8,
    parameter int INC_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_en,
    input logic [INC_W-1:0]  step_inc,
    input logic              call_en,
    input logic              ret_en,
    input logic [ADDR_W-1:0] call_target,
    input logic [ADDR_W-1:0] ret_addr,
    input logic              xchg_hi,
    input logic              xchg_lo,
    input logic [DATA_W-1:0] acc_in,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] spc,
    input logic [DATA_W-1:0] acc_out,
    input logic              acc_vld
);
    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (pc == '0 && spc == '0 && !acc_vld)); // R1
    AST_STEP_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !call_en && !ret_en) |=> pc == $past(pc + ADDR_W'(step_inc))); // R2
    AST_CALL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        call_en |=> (pc == $past(call_target) && spc == $past(ret_addr))); // R3
    AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !call_en) |=> pc == $past(spc)); // R4
    AST_XHI_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_hi && !call_en) |=> (acc_vld && acc_out == DATA_W'($past(spc) >> DATA_W)
            && spc[DATA_W-1:0] == $past(spc[DATA_W-1:0]))); // R8
    AST_XLO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_lo && !xchg_hi && !call_en) |=> (acc_vld && acc_out == $past(spc[DATA_W-1:0])
            && spc[DATA_W-1:0] == $past(acc_in))); // R9
    AST_CALL_NO_XCHG: assert property (@(posedge clk) disable iff (!rst_n)
        call_en |=> !acc_vld); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !call_en && !ret_en && !xchg_hi && !xchg_lo) |=> ($stable(pc) && $stable(spc) && !acc_vld)); // R12
endmodule

bind rtsave_unit rtsave_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INC_W(INC_W)) u_rtsave_checker (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_inc(step_inc), .call_en(call_en),
    .ret_en(ret_en), .call_target(call_target), .ret_addr(ret_addr), .xchg_hi(xchg_hi),
    .xchg_lo(xchg_lo), .acc_in(acc_in), .pc(pc), .spc(spc), .acc_out(acc_out), .acc_vld(acc_vld)
);

// File: tb/rtsave_unit_bench.sv
module rtsave_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 0, call_en = 0, ret_en = 0, xchg_hi = 0, xchg_lo = 0;
    logic [1:0]  step_inc = 0;
    logic [13:0] call_target = 0, ret_addr = 0;
    logic [7:0]  acc_in = 0;
    logic [13:0] pc, spc;
    logic [7:0]  acc_out;
    logic        acc_vld;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [13:0] e_pc = 0, e_spc = 0;
    logic [7:0]  e_acc = 0;
    logic        e_vld = 0;

    always #10 clk = ~clk;

    rtsave_unit u_rtsave_unit (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_inc(step_inc),
        .call_en(call_en), .ret_en(ret_en), .call_target(call_target), .ret_addr(ret_addr),
        .xchg_hi(xchg_hi), .xchg_lo(xchg_lo), .acc_in(acc_in),
        .pc(pc), .spc(spc), .acc_out(acc_out), .acc_vld(acc_vld)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drives the current strobes for one edge, updates the model, checks outputs.
    task automatic run_cycle(input string req);
        logic [13:0] o_spc = e_spc;
        if (call_en) begin
            e_pc = call_target; e_spc = ret_addr; e_vld = 0;
        end else begin
            if (ret_en)       e_pc = o_spc;
            else if (step_en) e_pc = 14'((int'(e_pc) + int'(step_inc)) % 16384);
            e_vld = 0;
            if (xchg_hi) begin
                e_acc = {2'b00, o_spc[13:8]};
                e_spc = {acc_in[5:0], o_spc[7:0]}; e_vld = 1;
            end else if (xchg_lo) begin
                e_acc = o_spc[7:0];
                e_spc = {o_spc[13:8], acc_in}; e_vld = 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(pc == e_pc, req, "pc", pc, e_pc);
        check(spc == e_spc, req, "spc", spc, e_spc);
        check(acc_vld == e_vld, req, "acc_vld", acc_vld, e_vld);
        if (e_vld) check(acc_out == e_acc, req, "acc_out", acc_out, e_acc);
        step_en = 0; call_en = 0; ret_en = 0; xchg_hi = 0; xchg_lo = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(pc == 0, "R1", "pc", pc, 0);
        check(spc == 0, "R1", "spc", spc, 0);
        check(acc_vld == 0, "R1", "acc_vld", acc_vld, 0);
        rst_n = 1;
        @(negedge clk);

        // R12: idle hold
        run_cycle("R12");

        // R2: step sweep with every increment, across the wrap point
        call_en = 1; call_target = 14'h3FF0; ret_addr = 14'h0123; run_cycle("R3");
        for (int k = 0; k < 40; k++) begin
            step_en = 1; step_inc = 2'(k); run_cycle("R2");
        end

        // R3 and R4: call / return sweep over targets
        for (int t = 0; t < 128; t++) begin
            call_en = 1; call_target = 14'(t * 131 + 7); ret_addr = 14'(t * 257 + 3);
            run_cycle("R3");
            step_en = 1; step_inc = 2'(t); run_cycle("R2");
            ret_en = 1; run_cycle("R4");
        end

        // R7: second call overwrites the first return address
        call_en = 1; call_target = 14'h0400; ret_addr = 14'h0111; run_cycle("R7");
        call_en = 1; call_target = 14'h0800; ret_addr = 14'h0222; run_cycle("R7");
        ret_en = 1; run_cycle("R7");
        check(pc == 14'h0222, "R7", "pc after return", pc, 14'h0222);

        // R8 and R9: exchange sweeps over every accumulator value
        for (int a = 0; a < 256; a++) begin
            xchg_hi = 1; acc_in = 8'(a); run_cycle("R8");
            xchg_lo = 1; acc_in = 8'(255 - a); run_cycle("R9");
        end

        // R5, R6, R10, R11: every strobe combination from varied register contents
        for (int v = 0; v < 24; v++) begin
            for (int m = 0; m < 32; m++) begin
                call_en = 1; call_target = 14'(v * 613 + 5); ret_addr = 14'(v * 1009 + 11);
                run_cycle("R3");
                step_en = m[0]; call_en = m[1]; ret_en = m[2]; xchg_hi = m[3]; xchg_lo = m[4];
                step_inc = 2'(v + m); call_target = 14'(m * 97 + v);
                ret_addr = 14'(m * 301 + 2 * v); acc_in = 8'(m * 37 + v);
                if (m[1])                  run_cycle("R5 R11");
                else if (m[2])             run_cycle("R6");
                else if (m[3] && m[4])     run_cycle("R10");
                else                       run_cycle("R12");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule